// File: doc/BRIEF.md
# Vehicle Detector Speed and Headway Meter

This block watches one vehicle presence detector and turns each passage into a timing record. It takes a synchronized detector level and a 1 kHz tick enable. For each vehicle it counts how many milliseconds the detector stays occupied and how many milliseconds passed since the previous vehicle arrived. It then derives a speed in whole miles per hour, assuming an 18-foot effective vehicle length. The record goes out as a single-cycle valid pulse carrying on-time, headway, speed and a first-vehicle flag.

Alongside the per-vehicle records, two running accumulators are kept for interval reporting: a vehicle count and a total occupied time in milliseconds. A clear strobe starts a new interval. An event that arrives in the same cycle as the strobe is kept in the new interval, so no vehicle and no millisecond is lost at the boundary.

The speed is produced by a shift-subtract divider that starts when the detector releases. Releases are assumed to be spaced further apart than the divider latency.

Top module: `vehSpeedMeter`

## Requirements
- R1: The reported on-time equals the number of cycles with both the detector high and the tick enable high, counted from the onset cycle (the first cycle sampled high) through the last cycle sampled high.
- R2: The reported headway equals the number of tick cycles from the previous vehicle's onset cycle (inclusive) to this vehicle's onset cycle (exclusive). The first vehicle after reset reports headway 0 with the first flag set to 1. Every later vehicle reports the first flag as 0.
- R3: The reported speed is round(12273 / on-time), rounding halves upward, clamped to the all-ones value of the speed field. An on-time of 0 reports the all-ones value. For example, 292 gives 42 and 809 gives 15.
- R4: The on-time and headway counters stop at all-ones (4095 in the bench build) and do not wrap. A vehicle whose on-time is at all-ones reports speed 0.
- R5: The valid output is a one-cycle pulse. It is high in the cycle that follows the NUM_W-th rising clock edge after the edge that samples the detector low after a high. NUM_W is max(CNT_W, ceil(log2(2*12273+1))) + 1, which is 16 in the bench build. At no other time is it high.
- R6: The vehicle count rises by exactly one at each detector onset and by nothing otherwise.
- R7: The occupied-time accumulator rises by one for each cycle with both the detector high and the tick enable high, and by nothing otherwise.
- R8: When the clear strobe is high, both accumulators load the same-cycle event alone: 1 if that cycle's onset (for the count) or occupied tick (for the time) occurs, and 0 otherwise.
- R9: During and right after reset, valid is low and both accumulators read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle 1 kHz time base enable |
| detIn | input | 1 | Synchronized detector level, high when occupied |
| clrAcc | input | 1 | Clears both accumulators for a new interval |
| resValid | output | 1 | One-cycle pulse marking a vehicle record |
| resOnTime | output | CNT_W | Occupancy duration in ms |
| resHeadway | output | CNT_W | Onset-to-onset headway in ms |
| resFirst | output | 1 | Set for the first vehicle after reset |
| resSpeed | output | SPD_W | Speed in whole mph |
| volCount | output | VOL_W | Vehicles counted in the interval |
| occTime | output | OCC_W | Occupied ms accumulated in the interval |

## Verification
The bench builds the meter with CNT_W set to 12 and leaves the other parameters at their defaults. With this setting, on-time and headway saturation at 4095 takes only a few thousand cycles, and the divider latency becomes 16 cycles. The tick enable is driven high every cycle, every third cycle, and not at all. These patterns cover normal speeds, the clamp to the maximum speed for one-tick and zero-tick occupancies, and zero speed at saturation. A clear strobe is also placed on the same cycle as an onset.

// File: rtl/vsmPkg.sv
package vsmPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vsmState_e;

  typedef struct packed {
    logic riseEv;
    logic fallEv;
    logic divLoad;
    logic divStep;
    logic resDone;
  } vsmCtrl_t;

endpackage

// File: rtl/vsmCtrl.sv
module vsmCtrl
  import vsmPkg::*;
#(
  parameter int NUM_W = 17
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     detIn,
  output vsmCtrl_t ctl
);

  localparam int SC_W = $clog2(NUM_W);

  logic            prevDet;
  vsmState_e       state;
  logic [SC_W-1:0] stepCnt;

  always_comb begin
    ctl         = '0;
    ctl.riseEv  = detIn & ~prevDet;
    ctl.fallEv  = ~detIn & prevDet;
    ctl.divLoad = ctl.fallEv && (state != ST_RUN);
    ctl.divStep = (state == ST_RUN);
    ctl.resDone = (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevDet <= 1'b0;
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      prevDet <= detIn;
      case (state)
        ST_IDLE: begin
          if (ctl.divLoad) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == SC_W'(NUM_W - 1)) begin
            state <= ST_DONE;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_DONE: begin
          if (ctl.divLoad) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vsmDatapath.sv
module vsmDatapath
  import vsmPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SPD_W   = 8,
  parameter int VOL_W   = 16,
  parameter int OCC_W   = 32,
  parameter int SPEED_K = 12273,
  parameter int NUM_W   = 17
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             detIn,
  input  logic             clrAcc,
  input  vsmCtrl_t         ctl,
  output logic             resValid,
  output logic [CNT_W-1:0] resOnTime,
  output logic [CNT_W-1:0] resHeadway,
  output logic             resFirst,
  output logic [SPD_W-1:0] resSpeed,
  output logic [VOL_W-1:0] volCount,
  output logic [OCC_W-1:0] occTime
);

  localparam int DEN_W   = CNT_W + 1;
  localparam int SPD_MAX = (2 ** SPD_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] onCnt, hdCnt, hdPend, onLat, hdLat;
  logic             firstPend, firstLat, seen;
  logic [NUM_W-1:0] dvd;
  logic [DEN_W-1:0] den, rem;
  logic [DEN_W:0]   trial;
  logic             trialGe;
  logic             occEv;

  assign occEv = detIn & tickEn;

  // occupancy and headway counters, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onCnt     <= '0;
      hdCnt     <= '0;
      hdPend    <= '0;
      firstPend <= 1'b0;
      seen      <= 1'b0;
    end else if (ctl.riseEv) begin
      onCnt     <= CNT_W'(tickEn);
      hdCnt     <= CNT_W'(tickEn);
      hdPend    <= seen ? hdCnt : '0;
      firstPend <= ~seen;
      seen      <= 1'b1;
    end else begin
      if (occEv && (onCnt != CNT_MAX)) onCnt <= onCnt + 1'b1;
      if (tickEn && (hdCnt != CNT_MAX)) hdCnt <= hdCnt + 1'b1;
    end
  end

  // restoring divider: (2K + t) / (2t) gives round-half-up of K / t
  assign trial   = {rem, dvd[NUM_W-1]};
  assign trialGe = (trial >= {1'b0, den});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onLat    <= '0;
      hdLat    <= '0;
      firstLat <= 1'b0;
      dvd      <= '0;
      den      <= '0;
      rem      <= '0;
    end else if (ctl.divLoad) begin
      onLat    <= onCnt;
      hdLat    <= hdPend;
      firstLat <= firstPend;
      dvd      <= NUM_W'(2 * SPEED_K) + NUM_W'(onCnt);
      den      <= {onCnt, 1'b0};
      rem      <= '0;
    end else if (ctl.divStep) begin
      rem <= trialGe ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
      dvd <= {dvd[NUM_W-2:0], trialGe};
    end
  end

  always_comb begin
    if (onLat == CNT_MAX) begin
      resSpeed = '0;
    end else if (dvd > NUM_W'(SPD_MAX)) begin
      resSpeed = SPD_W'(SPD_MAX);
    end else begin
      resSpeed = dvd[SPD_W-1:0];
    end
  end

  assign resValid   = ctl.resDone;
  assign resOnTime  = onLat;
  assign resHeadway = hdLat;
  assign resFirst   = firstLat;

  // interval accumulators; a same-cycle event survives a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      volCount <= '0;
      occTime  <= '0;
    end else if (clrAcc) begin
      volCount <= VOL_W'(ctl.riseEv);
      occTime  <= OCC_W'(occEv);
    end else begin
      if (ctl.riseEv) volCount <= volCount + 1'b1;
      if (occEv) occTime <= occTime + 1'b1;
    end
  end

endmodule

// File: rtl/vehSpeedMeter.sv
module vehSpeedMeter
  import vsmPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SPD_W   = 8,
  parameter int VOL_W   = 16,
  parameter int OCC_W   = 32,
  parameter int SPEED_K = 12273
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             detIn,
  input  logic             clrAcc,
  output logic             resValid,
  output logic [CNT_W-1:0] resOnTime,
  output logic [CNT_W-1:0] resHeadway,
  output logic             resFirst,
  output logic [SPD_W-1:0] resSpeed,
  output logic [VOL_W-1:0] volCount,
  output logic [OCC_W-1:0] occTime
);

  localparam int K_BITS = $clog2(2 * SPEED_K + 1);
  localparam int NUM_W  = ((CNT_W > K_BITS) ? CNT_W : K_BITS) + 1;

  vsmCtrl_t ctl;

  vsmCtrl #(
    .NUM_W(NUM_W)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .detIn(detIn),
    .ctl  (ctl)
  );

  vsmDatapath #(
    .CNT_W  (CNT_W),
    .SPD_W  (SPD_W),
    .VOL_W  (VOL_W),
    .OCC_W  (OCC_W),
    .SPEED_K(SPEED_K),
    .NUM_W  (NUM_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .detIn     (detIn),
    .clrAcc    (clrAcc),
    .ctl       (ctl),
    .resValid  (resValid),
    .resOnTime (resOnTime),
    .resHeadway(resHeadway),
    .resFirst  (resFirst),
    .resSpeed  (resSpeed),
    .volCount  (volCount),
    .occTime   (occTime)
  );

endmodule

// File: rtl/vsmChk.sv
module vsmChk #(
  parameter int CNT_W = 16,
  parameter int SPD_W = 8,
  parameter int VOL_W = 16,
  parameter int OCC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             detIn,
  input logic             clrAcc,
  input logic             resValid,
  input logic             resFirst,
  input logic [CNT_W-1:0] resOnTime,
  input logic [CNT_W-1:0] resHeadway,
  input logic [SPD_W-1:0] resSpeed,
  input logic [VOL_W-1:0] volCount,
  input logic [OCC_W-1:0] occTime
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R5

  AST_FIRST_HEADWAY: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resFirst) |-> (resHeadway == '0)); // R2

  AST_ZERO_ON_MAX_SPEED: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (resOnTime == '0)) |-> (&resSpeed)); // R3

  AST_SAT_ZERO_SPEED: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (&resOnTime)) |-> (resSpeed == '0)); // R4

  AST_VOL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !clrAcc |=> ((volCount == $past(volCount)) || (volCount == $past(volCount) + 1'b1))); // R6

  AST_VOL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!clrAcc && !detIn) |=> $stable(volCount)); // R6

  AST_OCC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!clrAcc && !detIn) |=> $stable(occTime)); // R7

  AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    clrAcc |=> ((volCount <= VOL_W'(1)) && (occTime <= OCC_W'(1)))); // R8

endmodule

bind vehSpeedMeter vsmChk #(
  .CNT_W(CNT_W),
  .SPD_W(SPD_W),
  .VOL_W(VOL_W),
  .OCC_W(OCC_W)
) u_vsmChk (
  .clk       (clk),
  .rstN      (rstN),
  .detIn     (detIn),
  .clrAcc    (clrAcc),
  .resValid  (resValid),
  .resFirst  (resFirst),
  .resOnTime (resOnTime),
  .resHeadway(resHeadway),
  .resSpeed  (resSpeed),
  .volCount  (volCount),
  .occTime   (occTime)
);

// File: tb/test_vehSpeedMeter.sv
`timescale 1ns/1ps
module test_vehSpeedMeter;

  localparam int CNT_W = 12;
  localparam int SPD_W = 8;
  localparam int VOL_W = 16;
  localparam int OCC_W = 32;
  localparam int MAXC  = (2 ** CNT_W) - 1;
  localparam int SMAX  = (2 ** SPD_W) - 1;
  localparam int LAT   = 16;   // max(12, 15) + 1 divider steps

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tickEn = 1'b0;
  logic             detIn = 1'b0;
  logic             clrAcc = 1'b0;
  logic             resValid, resFirst;
  logic [CNT_W-1:0] resOnTime, resHeadway;
  logic [SPD_W-1:0] resSpeed;
  logic [VOL_W-1:0] volCount;
  logic [OCC_W-1:0] occTime;

  int nTests = 0;
  int nFail  = 0;
  int tickPer = 1;
  bit running = 1'b0;

  always #2.5 clk = ~clk;

  vehSpeedMeter #(
    .CNT_W(CNT_W), .SPD_W(SPD_W), .VOL_W(VOL_W), .OCC_W(OCC_W)
  ) i_vehSpeedMeter (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .detIn(detIn), .clrAcc(clrAcc),
    .resValid(resValid), .resOnTime(resOnTime), .resHeadway(resHeadway),
    .resFirst(resFirst), .resSpeed(resSpeed), .volCount(volCount), .occTime(occTime)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expSpeed(int t);
    int r;
    if (t == MAXC) return 0;
    if (t == 0) return SMAX;
    r = $rtoi(12273.0 / t + 0.5);
    return (r > SMAX) ? SMAX : r;
  endfunction

  // behavioural reference model
  typedef struct {int due; int on; int hd; int first; int spd;} rec_t;
  rec_t q[$];
  int cyc, mOn, mHd, mHdPend, mFirstPend, mVol, mOcc;
  bit mPrev, mSeen;

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; mOn = 0; mHd = 0; mHdPend = 0; mFirstPend = 0;
      mVol = 0; mOcc = 0; mPrev = 0; mSeen = 0;
      q.delete();
    end else begin
      bit rise, fall, occEv;
      rise  = detIn && !mPrev;
      fall  = !detIn && mPrev;
      occEv = detIn && tickEn;
      cyc++;
      if (fall) q.push_back('{cyc + LAT, mOn, mHdPend, mFirstPend, expSpeed(mOn)});
      if (rise) begin
        mHdPend = mSeen ? mHd : 0;
        mFirstPend = mSeen ? 0 : 1;
        mSeen = 1;
        mHd = tickEn ? 1 : 0;
        mOn = tickEn ? 1 : 0;
      end else begin
        if (tickEn && mHd < MAXC) mHd++;
        if (occEv && mOn < MAXC) mOn++;
      end
      if (clrAcc) begin
        mVol = rise ? 1 : 0;
        mOcc = occEv ? 1 : 0;
      end else begin
        mVol += rise ? 1 : 0;
        mOcc += occEv ? 1 : 0;
      end
      mPrev = detIn;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      bit expV;
      expV = (q.size() > 0) && (q[0].due == cyc);
      check(resValid == expV, "R5", "valid", resValid, expV);
      if (expV) begin
        check(resOnTime == q[0].on, "R1", "on-time", resOnTime, q[0].on);
        check(resHeadway == q[0].hd, "R2", "headway", resHeadway, q[0].hd);
        check(resFirst == q[0].first, "R2", "first flag", resFirst, q[0].first);
        check(resSpeed == q[0].spd, (q[0].on == MAXC) ? "R4" : "R3", "speed",
              resSpeed, q[0].spd);
        void'(q.pop_front());
      end
      check(volCount == mVol, "R6", "volume", volCount, mVol);
      check(occTime == mOcc, "R7", "occupied time", occTime, mOcc);
    end
  end

  // tick generator: tickPer 1 = every cycle, 0 = never, n = every n-th
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (tickPer == 0) tickEn = 1'b0;
      else begin
        tickEn = (ph == 0);
        ph = (ph + 1 >= tickPer) ? 0 : ph + 1;
      end
    end
  end

  task automatic car(int onC, int gapC);
    @(negedge clk); detIn = 1'b1;
    repeat (onC) @(negedge clk);
    detIn = 1'b0;
    repeat (gapC - 1) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(resValid == 1'b0, "R9", "valid in reset", resValid, 0);
    check(volCount == '0, "R9", "volume in reset", volCount, 0);
    check(occTime == '0, "R9", "occupancy in reset", occTime, 0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    check(volCount == '0 && occTime == '0, "R9", "accumulators after reset",
          volCount + occTime, 0);

    tickPer = 1;
    car(292, 400);   // first vehicle, 42 mph
    car(809, 300);   // 15 mph
    car(200, 100);
    car(1, 60);      // one tick: clamp to max
    tickPer = 0;
    car(3, 60);      // zero ticks: max speed
    tickPer = 3;
    car(300, 200);
    tickPer = 1;
    car(MAXC + 500, 100);  // on-time saturation: speed 0
    car(150, MAXC + 600);  // long gap: headway saturation next
    car(120, 80);

    // R8: clear on the same cycle as an onset with a tick
    @(negedge clk); detIn = 1'b1; clrAcc = 1'b1;
    @(negedge clk); clrAcc = 1'b0;
    check(volCount == 1, "R8", "volume after clear with onset", volCount, 1);
    check(occTime == 1, "R8", "occupancy after clear with tick", occTime, 1);
    repeat (49) @(negedge clk);
    detIn = 1'b0;
    repeat (40) @(negedge clk);
    // R8: clear with no event
    clrAcc = 1'b1;
    @(negedge clk); clrAcc = 1'b0;
    check(volCount == 0, "R8", "volume after idle clear", volCount, 0);
    check(occTime == 0, "R8", "occupancy after idle clear", occTime, 0);
    car(250, 60);
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R5", "records outstanding", q.size(), 0);

    running = 1'b0;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule